// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs the external bus cycles of a small 8-bit processor core that addresses a 16-bit space. The upper address byte has its own output lines. The lower address byte and the data byte take turns on one shared bus. A one-cycle address strobe marks when the shared bus holds the address, and the data follows on the same wires.

The core presents a request: the address, the write data, a write flag and a flag that chooses I/O or memory space. The controller accepts the request only while it is idle and no other master wants the bus. Each transfer has three phases. In the address phase the strobe is high. In the data phase the active-low read or write strobe is low and the ready input is sampled. In the final phase read data is captured. A low ready stretches the data phase by one wait cycle for each low sample.

An external master can claim the bus with a hold request. The controller grants it with an acknowledge, but only between transfers, and it floats its outputs while the grant lasts. The block also gives out a clock at half its own rate and a stretched reset for attached devices.

Top module: `mux_bus_ctrl`

## Requirements
- R1: `addr_hi` carries address bits [15:8] of the current request from the address phase through the final phase. In the address phase `ad_o` carries address bits [7:0].
- R2: `ale` goes high for exactly one cycle at the start of every transfer, with `ad_oe` high during that cycle. Outside that cycle `ale` is low.
- R3: `io_m` is 1 for an I/O transfer and 0 for a memory transfer, for the whole transfer.
- R4: A read drives `rd_n` low and a write drives `wr_n` low, from the second cycle of the transfer through its last cycle. A write drives the write data on `ad_o` with `ad_oe` high. `rd_n` and `wr_n` are never low together.
- R5: Each cycle in which `ready` is sampled low in the data phase adds one wait cycle. A strobe stays low for 2 + (number of wait cycles) cycles.
- R6: When `hold` is seen while idle, `hlda` goes high on the next cycle. While `hlda` is high, `ad_oe`, `hi_oe` and `req_ready` are 0, `ale` is 0 and both strobes are 1. `hlda` returns to 0 on the cycle after `hold` is removed.
- R7: `clk_out` is 0 in reset and then inverts on every clock, so it runs at half the input rate.
- R8: While `rst_n` is low, `rst_out` is 1, `ale` and `ad_oe` are 0, and both strobes are 1. `rst_out` stays 1 for RST_OUT_LEN (default 4) clocks after reset is released.
- R9: A `hold` raised during a transfer is not granted until the transfer ends. `hlda` rises in the same cycle as `done`.
- R10: `ad_oe` is 0 while `rd_n` is low and while the controller is idle.
- R11: `done` is high for exactly one cycle after the final phase. During that cycle `rdata` holds the byte read from the shared bus in the final phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core requests a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request is taken on this clock edge |
| done | output | 1 | One-cycle end-of-transfer strobe |
| rdata | output | 8 | Read data, valid with done |
| ready | input | 1 | Device ready; low inserts a wait cycle |
| hold | input | 1 | External master requests the bus |
| hlda | output | 1 | Bus granted to the external master |
| addr_hi | output | 8 | Upper address byte |
| hi_oe | output | 1 | Output enable for addr_hi, strobes and io_m |
| ad_o | output | 8 | Shared bus, outgoing value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_i | input | 8 | Shared bus, incoming value |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | 1 = I/O transfer, 0 = memory |
| clk_out | output | 1 | Clock at half the input rate |
| rst_out | output | 1 | Stretched reset for attached devices |

## Verification
A corrupted sequencer state appears on the pins within one clock. Examples: an address strobe lasting two cycles, a read strobe while the shared bus is still driven, or an acknowledge while a strobe is low. The cycle checks catch these at once. A stale request latch shows up only when the transfer ends, as a wrong latched address, a wrong I/O flag or wrong data beside `done`. A wrong wait count shows up as a strobe of the wrong length, which is measured when that transfer completes.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ADR  = 3'd1,
      ST_DAT  = 3'd2,
      ST_WAIT = 3'd3,
      ST_FIN  = 3'd4,
      ST_GRNT = 3'd5
   } bus_st_e;
endpackage

// File: rtl/mbc_clkrst.sv
module mbc_clkrst #(
   parameter int RST_OUT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic clk_out,
   output logic rst_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_out <= 1'b0;
      else        clk_out <= ~clk_out;
   end

   generate
      if (RST_OUT_LEN == 0) begin : g_rst_pass
         assign rst_out = ~rst_n;
      end else begin : g_rst_stretch
         localparam int CW = $clog2(RST_OUT_LEN + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt <= CW'(RST_OUT_LEN);
            else if (cnt != 0) cnt <= cnt - 1'b1;
         end
         assign rst_out = (cnt != 0);
      end
   endgenerate
endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
   import mbc_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          req_io,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          ready,
   input  logic          hold,
   input  logic [DW-1:0] ad_i,
   output bus_st_e       st,
   output logic          req_ready,
   output logic          cur_write,
   output logic          cur_io,
   output logic [AW-1:0] cur_addr,
   output logic [DW-1:0] cur_wdata,
   output logic          done,
   output logic [DW-1:0] rdata
);
   bus_st_e st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE: if (hold) st_nx = ST_GRNT;
                  else if (req_valid) st_nx = ST_ADR;
         ST_ADR:  st_nx = ST_DAT;
         ST_DAT:  st_nx = ready ? ST_FIN : ST_WAIT;
         ST_WAIT: st_nx = ready ? ST_FIN : ST_WAIT;
         ST_FIN:  st_nx = hold ? ST_GRNT : ST_IDLE;
         ST_GRNT: st_nx = hold ? ST_GRNT : ST_IDLE;
         default: st_nx = ST_IDLE;
      endcase
   end

   assign req_ready = (st == ST_IDLE) && !hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cur_write <= 1'b0;
         cur_io    <= 1'b0;
         cur_addr  <= '0;
         cur_wdata <= '0;
         done      <= 1'b0;
         rdata     <= '0;
      end else begin
         st   <= st_nx;
         done <= (st == ST_FIN);
         if (req_ready && req_valid) begin
            cur_write <= req_write;
            cur_io    <= req_io;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
         end
         if (st == ST_FIN && !cur_write) rdata <= ad_i;
      end
   end
endmodule

// File: rtl/mbc_drive.sv
module mbc_drive
   import mbc_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  bus_st_e            st,
   input  logic               cur_write,
   input  logic               cur_io,
   input  logic [AW-1:0]      cur_addr,
   input  logic [DW-1:0]      cur_wdata,
   output logic [AW-DW-1:0]   addr_hi,
   output logic               hi_oe,
   output logic [DW-1:0]      ad_o,
   output logic               ad_oe,
   output logic               ale,
   output logic               rd_n,
   output logic               wr_n,
   output logic               io_m,
   output logic               hlda
);
   logic data_ph;

   always_comb begin
      data_ph = (st == ST_DAT) || (st == ST_WAIT) || (st == ST_FIN);
      hlda    = (st == ST_GRNT);
      hi_oe   = !hlda;
      addr_hi = cur_addr[AW-1:DW];
      io_m    = cur_io;
      ale     = (st == ST_ADR);
      rd_n    = !(data_ph && !cur_write);
      wr_n    = !(data_ph && cur_write);
      ad_oe   = ale || (data_ph && cur_write);
      ad_o    = ale ? cur_addr[DW-1:0] : cur_wdata;
   end
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
   import mbc_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 8,
   parameter int RST_OUT_LEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          req_io,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ready,
   output logic          done,
   output logic [DW-1:0] rdata,
   input  logic          ready,
   input  logic          hold,
   output logic          hlda,
   output logic [AW-DW-1:0] addr_hi,
   output logic          hi_oe,
   output logic [DW-1:0] ad_o,
   output logic          ad_oe,
   input  logic [DW-1:0] ad_i,
   output logic          ale,
   output logic          rd_n,
   output logic          wr_n,
   output logic          io_m,
   output logic          clk_out,
   output logic          rst_out
);
   localparam int HW = AW - DW;

   if (DW < 1)       begin : g_bad_dw  $error("DW must be at least 1"); end
   if (HW < 1)       begin : g_bad_aw  $error("AW must exceed DW"); end
   if (RST_OUT_LEN < 0) begin : g_bad_rl $error("RST_OUT_LEN must not be negative"); end

   bus_st_e       st;
   logic          cur_write;
   logic          cur_io;
   logic [AW-1:0] cur_addr;
   logic [DW-1:0] cur_wdata;

   mbc_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .ready(ready), .hold(hold), .ad_i(ad_i),
      .st(st), .req_ready(req_ready),
      .cur_write(cur_write), .cur_io(cur_io),
      .cur_addr(cur_addr), .cur_wdata(cur_wdata),
      .done(done), .rdata(rdata)
   );

   mbc_drive #(.AW(AW), .DW(DW)) u_drive (
      .st(st), .cur_write(cur_write), .cur_io(cur_io),
      .cur_addr(cur_addr), .cur_wdata(cur_wdata),
      .addr_hi(addr_hi), .hi_oe(hi_oe), .ad_o(ad_o), .ad_oe(ad_oe),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .hlda(hlda)
   );

   mbc_clkrst #(.RST_OUT_LEN(RST_OUT_LEN)) u_clkrst (
      .clk(clk), .rst_n(rst_n), .clk_out(clk_out), .rst_out(rst_out)
   );
endmodule

// File: rtl/mbc_chk.sv
module mbc_chk
   import mbc_pkg::*;
(
   input logic    clk,
   input logic    rst_n,
   input bus_st_e st,
   input logic    ready,
   input logic    hold,
   input logic    hlda,
   input logic    ale,
   input logic    ad_oe,
   input logic    hi_oe,
   input logic    rd_n,
   input logic    wr_n,
   input logic    done
);
   p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   p_ale_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ad_oe && hi_oe && rd_n && wr_n));

   p_read_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !ad_oe);

   p_grant_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> (!ad_oe && !hi_oe && !ale && rd_n && wr_n));

   p_grant_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hlda && hold) |=> hlda);

   p_grant_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hlda && !hold) |=> !hlda);

   p_no_grant_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> !hlda);

   p_wait_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_DAT || st == ST_WAIT) && !ready) |=> (st == ST_WAIT && (!rd_n || !wr_n)));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_reset_quiet_r8: assert property (@(posedge clk)
      !rst_n |-> (!ale && !ad_oe && rd_n && wr_n && !done));
endmodule

bind mux_bus_ctrl mbc_chk u_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .ready(ready), .hold(hold),
   .hlda(hlda), .ale(ale), .ad_oe(ad_oe), .hi_oe(hi_oe),
   .rd_n(rd_n), .wr_n(wr_n), .done(done)
);

// File: tb/test_mux_bus_ctrl.sv
`timescale 1ns/100ps
module test_mux_bus_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, done, hlda, hi_oe, ad_oe, ale, rd_n, wr_n, io_m;
   logic        clk_out, rst_out;
   logic [7:0]  rdata, addr_hi, ad_o;
   logic [7:0]  ad_i = '0;
   logic        ready = 1'b1, hold = 1'b0;

   int total = 0, bad = 0;
   bit finished = 0;

   typedef struct {
      bit          wr;
      bit          io;
      logic [15:0] addr;
      logic [7:0]  data;
      int          waits;
   } item_t;
   item_t sb_q[$];

   int          wait_left = 0;
   int          strobe_cnt = 0;
   logic [15:0] lat_addr = '0;
   logic        lat_io = 1'b0;
   logic [7:0]  wr_seen = '0;
   logic        prev_done = 1'b0;

   always #2.5 clk = ~clk;

   mux_bus_ctrl i_mux_bus_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .done(done), .rdata(rdata), .ready(ready),
      .hold(hold), .hlda(hlda), .addr_hi(addr_hi), .hi_oe(hi_oe),
      .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .ale(ale), .rd_n(rd_n),
      .wr_n(wr_n), .io_m(io_m), .clk_out(clk_out), .rst_out(rst_out)
   );

   function automatic logic [7:0] dev_data(logic [15:0] a, logic io);
      return a[7:0] ^ a[15:8] ^ (io ? 8'h5A : 8'h00) ^ 8'h3C;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // device model and scoreboard monitor, one process at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (ale) begin
            chk(ad_oe && hi_oe, "R2 shared bus driven with ale", {ad_oe, hi_oe}, 2'b11);
            lat_addr = {addr_hi, ad_o};
            lat_io   = io_m;
         end
         if (!rd_n || !wr_n) begin
            strobe_cnt++;
            if (!rd_n) ad_i = dev_data(lat_addr, lat_io);
            if (!wr_n) wr_seen = ad_o;
            if (wait_left > 0) begin
               ready = 1'b0;
               wait_left--;
            end else ready = 1'b1;
         end else ready = 1'b1;
         if (done) begin
            chk(!prev_done, "R11 done single cycle", prev_done, 0);
            if (sb_q.size() == 0) chk(0, "R11 done without request", 1, 0);
            else begin
               item_t it;
               it = sb_q.pop_front();
               chk(lat_addr == it.addr, "R1 address on bus", lat_addr, it.addr);
               chk(lat_io == it.io, "R3 io_m value", lat_io, it.io);
               chk(strobe_cnt == 2 + it.waits, "R5 strobe length", strobe_cnt, 2 + it.waits);
               if (it.wr) chk(wr_seen == it.data, "R4 write data", wr_seen, it.data);
               else       chk(rdata == it.data, "R11 read data", rdata, it.data);
            end
            strobe_cnt = 0;
         end
         prev_done = done;
      end
   end

   task automatic do_xfer(input bit wr, input bit io, input logic [15:0] a,
                          input logic [7:0] wd, input int waits);
      item_t it;
      @(negedge clk);
      wait_left = waits;
      req_valid = 1'b1; req_write = wr; req_io = io; req_addr = a; req_wdata = wd;
      while (!req_ready) @(negedge clk);
      it.wr = wr; it.io = io; it.addr = a; it.waits = waits;
      it.data = wr ? wd : dev_data(a, io);
      sb_q.push_back(it);
      @(negedge clk);
      req_valid = 1'b0;
      while (sb_q.size() != 0) @(negedge clk);
   endtask

   initial begin
      #(5ns * 20000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: quiet outputs in reset
      chk(rst_out == 1'b1, "R8 rst_out in reset", rst_out, 1);
      chk(ale == 1'b0 && ad_oe == 1'b0, "R8 ale/ad_oe in reset", {ale, ad_oe}, 0);
      chk(rd_n && wr_n, "R8 strobes in reset", {rd_n, wr_n}, 2'b11);
      chk(clk_out == 1'b0, "R7 clk_out in reset", clk_out, 0);
      chk(ad_oe == 1'b0, "R10 bus floats idle", ad_oe, 0);
      rst_n = 1'b1;
      for (int i = 1; i <= 4; i++) begin
         @(negedge clk);
         chk(rst_out == (i < 4), "R8 rst_out stretch", rst_out, i < 4);
      end
      // R7: half-rate clock
      for (int i = 0; i < 6; i++) begin
         logic prev;
         prev = clk_out;
         @(negedge clk);
         chk(clk_out == ~prev, "R7 clk_out toggles", clk_out, ~prev);
      end
      // R4 R1 R3 R5 R11: transfers of several kinds
      do_xfer(0, 0, 16'h12A5, 8'h00, 0);
      do_xfer(0, 1, 16'h00F3, 8'h00, 2);
      do_xfer(1, 0, 16'hFFFF, 8'hC3, 1);
      do_xfer(1, 1, 16'h0040, 8'h7E, 0);
      do_xfer(0, 0, 16'h0000, 8'h00, 3);
      do_xfer(1, 0, 16'h8001, 8'h18, 3);
      chk(ad_oe == 1'b0, "R10 bus floats idle after write", ad_oe, 0);
      // R6: hold while idle
      @(negedge clk); hold = 1'b1;
      @(negedge clk);
      chk(hlda == 1'b1, "R6 hlda after hold", hlda, 1);
      chk(!ad_oe && !hi_oe && !req_ready, "R6 bus released", {ad_oe, hi_oe, req_ready}, 0);
      @(negedge clk);
      chk(hlda == 1'b1, "R6 hlda kept", hlda, 1);
      hold = 1'b0;
      @(negedge clk);
      chk(hlda == 1'b0, "R6 hlda drops", hlda, 0);
      chk(hi_oe == 1'b1, "R6 hi_oe back", hi_oe, 1);
      // R9: hold arriving mid-transfer
      fork
         do_xfer(0, 1, 16'h5A5A, 8'h00, 1);
         begin
            while (rd_n) @(negedge clk);
            hold = 1'b1;
            while (!rd_n) begin
               chk(hlda == 1'b0, "R9 no grant mid transfer", hlda, 0);
               @(negedge clk);
            end
            chk(hlda == 1'b1 && done == 1'b1, "R9 grant with done", {hlda, done}, 2'b11);
         end
      join
      @(negedge clk);
      chk(hlda == 1'b1, "R9 grant held", hlda, 1);
      hold = 1'b0;
      @(negedge clk);
      chk(hlda == 1'b0, "R6 release after transfer grant", hlda, 0);
      do_xfer(1, 0, 16'h3C00, 8'hA5, 0);
      repeat (3) @(negedge clk);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule